// File: doc/BRIEF.md
# Low-Power SDRAM Initialization Sequencer

This block takes a low-power SDRAM from reset to a usable state. After reset it keeps the memory deselected for a power-up pause whose length is derived from the clock frequency. It then issues, in fixed order, a precharge of all banks, a set of auto-refresh commands, a write of the standard mode register, and a write of the extended mode register. Only after that does it raise a done flag. A memory controller holds off normal traffic until the flag is high, then takes over the command pins.

The mode register word is built from configuration inputs: burst length, CAS latency, burst type and operating mode. The extended word is built from a partial-array refresh selection and a temperature range. All configuration inputs are sampled once, on the clock edge that issues the precharge. Parameterized gaps separate each pair of commands: one after the precharge, one after each refresh, and one after each register write.

Top module: `lpsdr_init_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after a reset edge, all four command pins are high (deselect), `sd_ba` and `sd_addr` are zero and `init_done` is low.
- R2: The pause lasts PAUSE_CYC = CLK_MHZ*PAUSE_US cycles. Deselect is held until the first command, which is registered on the PAUSE_CYC-th rising edge after reset is released.
- R3: The first command is a precharge (cs_n, ras_n and we_n low; cas_n high) with `sd_addr[10]` high, which selects all banks.
- R4: Exactly max(REFRESH_CNT, 8) auto-refresh commands are issued (cs_n, ras_n and cas_n low; we_n high). The first comes T_RP cycles after the precharge, and each following one comes T_RFC cycles after the previous one.
- R5: The mode register write (all four command pins low, `sd_ba` = 2'b00) comes T_RFC cycles after the last refresh.
- R6: The extended mode register write comes T_MRD cycles after the mode register write. It uses all four command pins low and `sd_ba` = 2'b10.
- R7: `init_done` rises T_MRD cycles after the extended write and stays high until the next reset.
- R8: Mode word bits [2:0] encode the burst length from `cfg_burst_len`: 0→000 (1), 1→001 (2), 2→010 (4), 3→011 (8), and 4 to 7→111 (full page).
- R9: Mode word bits [6:4] hold the CAS latency: `cfg_cas_lat` values 1, 2 and 3 are written as is, and value 0 is written as 3.
- R10: Mode word bit 3 is the burst type and bit 9 is the operating mode (1 = burst read with single write). Every other mode word bit is zero.
- R11: Extended word bits [2:0] encode the partial-array selection from `cfg_array_sel`: 0→000 (full), 1→001 (half), 2→010 (quarter), 3→101 (eighth), and 4 to 7→110 (sixteenth). Bits [4:3] carry `cfg_temp_sel` (00 = 70°, 01 = 45°, 10 = 15°, 11 = 85°). Every other bit is zero.
- R12: Configuration is sampled on the edge that issues the precharge. Changes made later, including after `init_done`, have no effect on the register words or on the pins until a new reset.
- R13: Between commands and after `init_done`, a NOP is driven: cs_n low, ras_n/cas_n/we_n high, and `sd_ba` and `sd_addr` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | 2 | CAS latency select |
| cfg_burst_len | input | 3 | Burst length select |
| cfg_burst_type | input | 1 | Burst type (0 sequential, 1 interleaved) |
| cfg_op_mode | input | 1 | 1 = burst read with single write |
| cfg_array_sel | input | 3 | Partial-array refresh select |
| cfg_temp_sel | input | 2 | Temperature range code |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence finished |

## Verification
Every output is a register, so a command becomes visible in the cycle after the edge that decides it. The bench counts rising edges from reset release and derives the schedule from the parameters alone. The precharge falls on edge PAUSE_CYC, and the refreshes start T_RP later at a spacing of T_RFC. The mode write comes T_RFC after the last refresh, the extended write T_MRD after that, and `init_done` T_MRD later again. All pins are sampled on the falling edge that follows each counted rising edge, so every expected value is compared half a cycle after the register updates. The configuration is changed during the pause, after the precharge and after completion, to show the single sampling point.

// File: rtl/lpsdr_init_pkg.sv
package lpsdr_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    PH_PAUSE,
    PH_PRE_WAIT,
    PH_REF_WAIT,
    PH_MRS_WAIT,
    PH_EMRS_WAIT,
    PH_READY
  } init_phase_e;

  typedef struct packed {
    logic [1:0] cas_lat;
    logic [2:0] burst_len;
    logic       burst_type;
    logic       op_mode;
    logic [2:0] array_sel;
    logic [1:0] temp_sel;
  } init_cfg_t;

endpackage

// File: rtl/lpsdr_gap_timer.sv
module lpsdr_gap_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/lpsdr_mode_words.sv
module lpsdr_mode_words
  import lpsdr_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  init_cfg_t          cfg,
  output logic [ADDR_W-1:0]  mode_word,
  output logic [ADDR_W-1:0]  ext_word
);
  logic [2:0] bl_code;
  logic [2:0] cl_code;
  logic [2:0] pa_code;

  always_comb begin
    case (cfg.burst_len)
      3'd0:    bl_code = 3'b000;
      3'd1:    bl_code = 3'b001;
      3'd2:    bl_code = 3'b010;
      3'd3:    bl_code = 3'b011;
      default: bl_code = 3'b111;
    endcase
    cl_code = (cfg.cas_lat == 2'd0) ? 3'd3 : {1'b0, cfg.cas_lat};
    case (cfg.array_sel)
      3'd0:    pa_code = 3'b000;
      3'd1:    pa_code = 3'b001;
      3'd2:    pa_code = 3'b010;
      3'd3:    pa_code = 3'b101;
      default: pa_code = 3'b110;
    endcase

    mode_word      = '0;
    mode_word[2:0] = bl_code;
    mode_word[3]   = cfg.burst_type;
    mode_word[6:4] = cl_code;
    mode_word[9]   = cfg.op_mode;

    ext_word       = '0;
    ext_word[2:0]  = pa_code;
    ext_word[4:3]  = cfg.temp_sel;
  end
endmodule

// File: rtl/lpsdr_init_seq.sv
module lpsdr_init_seq
  import lpsdr_init_pkg::*;
#(
  parameter int CLK_MHZ     = 50,
  parameter int PAUSE_US    = 200,
  parameter int REFRESH_CNT = 8,
  parameter int T_RP        = 3,
  parameter int T_RFC       = 7,
  parameter int T_MRD       = 2,
  parameter int ADDR_W      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_cas_lat,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic              cfg_op_mode,
  input  logic [2:0]        cfg_array_sel,
  input  logic [1:0]        cfg_temp_sel,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [1:0]        sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int REF_N     = (REFRESH_CNT < 8) ? 8 : REFRESH_CNT;
  localparam int RC_W      = $clog2(REF_N + 1);
  localparam int TW        = $clog2(PAUSE_CYC + T_RP + T_RFC + T_MRD + 2);
  localparam int ALL_BIT   = 10;
  localparam logic [1:0] BA_MODE = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b10;

  init_phase_e        phase;
  sd_cmd_e            cmd_q;
  logic [1:0]         ba_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               done_q;
  logic [RC_W-1:0]    ref_cnt;
  init_cfg_t          cfg_in, cfg_q;
  logic [ADDR_W-1:0]  mode_word, ext_word;
  logic               tmr_zero, tmr_load;
  logic [TW-1:0]      tmr_val;
  logic               last_ref;

  assign cfg_in = '{cas_lat: cfg_cas_lat, burst_len: cfg_burst_len,
                    burst_type: cfg_burst_type, op_mode: cfg_op_mode,
                    array_sel: cfg_array_sel, temp_sel: cfg_temp_sel};

  assign last_ref = (ref_cnt == RC_W'(REF_N));

  lpsdr_mode_words #(.ADDR_W(ADDR_W)) u_words (
    .cfg       (cfg_q),
    .mode_word (mode_word),
    .ext_word  (ext_word)
  );

  lpsdr_gap_timer #(.W(TW), .RST_VAL(PAUSE_CYC - 1)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    tmr_load = tmr_zero && (phase != PH_READY);
    case (phase)
      PH_PAUSE:    tmr_val = TW'(T_RP - 1);
      PH_PRE_WAIT: tmr_val = TW'(T_RFC - 1);
      PH_REF_WAIT: tmr_val = last_ref ? TW'(T_MRD - 1) : TW'(T_RFC - 1);
      PH_MRS_WAIT: tmr_val = TW'(T_MRD - 1);
      default:     tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_PAUSE;
      cmd_q   <= CMD_DESEL;
      ba_q    <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      ref_cnt <= '0;
      cfg_q   <= '0;
    end else begin
      cmd_q  <= (phase == PH_PAUSE) ? CMD_DESEL : CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      if (tmr_zero) begin
        case (phase)
          PH_PAUSE: begin
            cmd_q           <= CMD_PRE;
            addr_q[ALL_BIT] <= 1'b1;
            cfg_q           <= cfg_in;
            phase           <= PH_PRE_WAIT;
          end
          PH_PRE_WAIT: begin
            cmd_q   <= CMD_REF;
            ref_cnt <= RC_W'(1);
            phase   <= PH_REF_WAIT;
          end
          PH_REF_WAIT: begin
            if (last_ref) begin
              cmd_q  <= CMD_LMR;
              ba_q   <= BA_MODE;
              addr_q <= mode_word;
              phase  <= PH_MRS_WAIT;
            end else begin
              cmd_q   <= CMD_REF;
              ref_cnt <= ref_cnt + 1'b1;
            end
          end
          PH_MRS_WAIT: begin
            cmd_q  <= CMD_LMR;
            ba_q   <= BA_EXT;
            addr_q <= ext_word;
            phase  <= PH_EMRS_WAIT;
          end
          PH_EMRS_WAIT: begin
            done_q <= 1'b1;
            phase  <= PH_READY;
          end
          default: ;
        endcase
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign init_done = done_q;
endmodule

// File: rtl/lpsdr_init_chk.sv
module lpsdr_init_chk #(
  parameter int ADDR_W = 12,
  parameter int T_RFC  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              done
);
  logic rst_d;
  logic is_nop, is_pre, is_ref, is_lmr;

  assign is_nop = !cs_n && ras_n && cas_n && we_n;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n && we_n;
  assign is_lmr = !cs_n && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst_d) begin
      a_r1_reset_idle: assert (cs_n && !done && addr == '0 && ba == '0);
    end
  end

  a_r2_desel_not_done: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> (!done && ras_n && cas_n && we_n));

  a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> addr[10]);

  a_r6_lmr_bank: assert property (@(posedge clk) disable iff (rst)
    is_lmr |-> (ba == 2'b00 || ba == 2'b10));

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  a_r13_done_nop: assert property (@(posedge clk) disable iff (rst)
    done |-> (is_nop && addr == '0 && ba == '0));

  generate
    if (T_RFC > 1) begin : g_ref_gap
      a_r4_ref_then_nop: assert property (@(posedge clk) disable iff (rst)
        is_ref |=> is_nop);
    end
  endgenerate
endmodule

bind lpsdr_init_seq lpsdr_init_chk #(.ADDR_W(ADDR_W), .T_RFC(T_RFC)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (sd_cs_n),
  .ras_n (sd_ras_n),
  .cas_n (sd_cas_n),
  .we_n  (sd_we_n),
  .ba    (sd_ba),
  .addr  (sd_addr),
  .done  (init_done)
);

// File: tb/sim_lpsdr_init_seq.sv
module sim_lpsdr_init_seq;
  localparam int P      = 50 * 200;
  localparam int TRP    = 3;
  localparam int TRFC   = 7;
  localparam int TMRD   = 2;
  localparam int NREF   = 8;
  localparam int AW     = 12;
  localparam int T_REF0 = P + TRP;
  localparam int T_MRS  = T_REF0 + NREF * TRFC;
  localparam int T_EMRS = T_MRS + TMRD;
  localparam int T_DONE = T_EMRS + TMRD;
  localparam int T_END  = T_DONE + 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cl;
  logic [2:0] bl;
  logic bt, op;
  logic [2:0] pa;
  logic [1:0] tp;
  logic cs_n, ras_n, cas_n, we_n;
  logic [1:0] ba;
  logic [AW-1:0] addr;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lpsdr_init_seq u0 (
    .clk(clk), .rst(rst), .cfg_cas_lat(cl), .cfg_burst_len(bl),
    .cfg_burst_type(bt), .cfg_op_mode(op), .cfg_array_sel(pa),
    .cfg_temp_sel(tp), .sd_cs_n(cs_n), .sd_ras_n(ras_n),
    .sd_cas_n(cas_n), .sd_we_n(we_n), .sd_ba(ba), .sd_addr(addr),
    .init_done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_mode(input logic [2:0] b, input logic [1:0] c,
                                              input logic t, input logic o);
    logic [AW-1:0] w = '0;
    w[2:0] = (b < 3'd4) ? b : 3'b111;
    w[3]   = t;
    w[6:4] = (c == 2'd0) ? 3'd3 : {1'b0, c};
    w[9]   = o;
    return w;
  endfunction

  function automatic logic [AW-1:0] exp_ext(input logic [2:0] s, input logic [1:0] t);
    logic [AW-1:0] w = '0;
    case (s)
      3'd0: w[2:0] = 3'b000;
      3'd1: w[2:0] = 3'b001;
      3'd2: w[2:0] = 3'b010;
      3'd3: w[2:0] = 3'b101;
      default: w[2:0] = 3'b110;
    endcase
    w[4:3] = t;
    return w;
  endfunction

  task automatic set_cfg(input logic [2:0] b, input logic [1:0] c, input logic t,
                         input logic o, input logic [2:0] s, input logic [1:0] q);
    bl = b; cl = c; bt = t; op = o; pa = s; tp = q;
  endtask

  task automatic run_seq(input string name, input logic [2:0] b, input logic [1:0] c,
                         input logic t, input logic o, input logic [2:0] s,
                         input logic [1:0] q);
    int pause_bad = 0, ref_bad = 0, gap_bad = 0, done_bad = 0, late_bad = 0;
    int refs = 0;
    logic [3:0] pre_cmd = '0, mrs_cmd = '0, emrs_cmd = '0;
    logic [AW-1:0] pre_addr = '0, mrs_addr = '0, emrs_addr = '0;
    logic [1:0] mrs_ba = '0, emrs_ba = '0;
    logic [AW-1:0] em, ee;
    em = exp_mode(b, c, t, o);
    ee = exp_ext(s, q);
    // start with wrong config; the real one is applied during the pause
    set_cfg(~b, ~c, ~t, ~o, ~s, ~q);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cs_n && ras_n && cas_n && we_n && !done && addr == '0 && ba == '0,
          {"R1 reset idle ", name}, {cs_n, ras_n, cas_n, we_n, done}, 5'b11110);
    rst = 1'b0;
    for (int n = 1; n <= T_END; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 100) set_cfg(b, c, t, o, s, q);
      if (n == P + 10) set_cfg(b + 3'd1, c + 2'd1, ~t, ~o, s + 3'd2, q + 2'd1);
      if (n == T_DONE + 5) set_cfg(~b, ~c, t, o, ~s, ~q);
      if (done != (n >= T_DONE)) done_bad++;
      if (n < P) begin
        if (!(cs_n && ras_n && cas_n && we_n)) pause_bad++;
      end else if (n == P) begin
        pre_cmd = {cs_n, ras_n, cas_n, we_n}; pre_addr = addr;
      end else if (n >= T_REF0 && n < T_MRS && ((n - T_REF0) % TRFC) == 0) begin
        if ({cs_n, ras_n, cas_n, we_n} != 4'b0001) ref_bad++;
        else refs++;
      end else if (n == T_MRS) begin
        mrs_cmd = {cs_n, ras_n, cas_n, we_n}; mrs_ba = ba; mrs_addr = addr;
      end else if (n == T_EMRS) begin
        emrs_cmd = {cs_n, ras_n, cas_n, we_n}; emrs_ba = ba; emrs_addr = addr;
      end else begin
        if ({cs_n, ras_n, cas_n, we_n} != 4'b0111 || addr != '0 || ba != '0) begin
          gap_bad++;
          if (n > T_DONE + 5) late_bad++;
        end
      end
    end
    check(pause_bad == 0, {"R2 pause deselect ", name}, pause_bad, 0);
    check(pre_cmd == 4'b0010 && pre_addr[10], {"R3 precharge all ", name},
          {pre_cmd, pre_addr}, {4'b0010, 12'h400});
    check(ref_bad == 0 && refs == NREF, {"R4 refresh count/spacing ", name}, refs, NREF);
    check(mrs_cmd == 4'b0000 && mrs_ba == 2'b00, {"R5 mode write ", name},
          {mrs_cmd, mrs_ba}, 6'b0);
    check(emrs_cmd == 4'b0000 && emrs_ba == 2'b10, {"R6 ext write ", name},
          {emrs_cmd, emrs_ba}, 6'b000010);
    check(done_bad == 0, {"R7 done timing ", name}, done_bad, 0);
    check(mrs_addr[2:0] == em[2:0], {"R8 burst length ", name}, mrs_addr[2:0], em[2:0]);
    check(mrs_addr[6:4] == em[6:4], {"R9 cas latency ", name}, mrs_addr[6:4], em[6:4]);
    check(mrs_addr == em, {"R10 mode word ", name}, mrs_addr, em);
    check(emrs_addr == ee, {"R11 ext word ", name}, emrs_addr, ee);
    // R12: words follow the value held at precharge, later changes ignored
    check(mrs_addr == em && emrs_addr == ee && late_bad == 0,
          {"R12 config sampled once ", name}, late_bad, 0);
    check(gap_bad == 0, {"R13 nop between ", name}, gap_bad, 0);
  endtask

  task automatic test_short_burst;
    run_seq("bl1_cl2", 3'd0, 2'd2, 1'b0, 1'b0, 3'd0, 2'b11);
  endtask

  task automatic test_full_page;
    run_seq("fullpage_cl3", 3'd4, 2'd3, 1'b1, 1'b1, 3'd2, 2'b10);
  endtask

  task automatic test_coerced_codes;
    run_seq("bl8_cl0", 3'd3, 2'd0, 1'b1, 1'b0, 3'd7, 2'b01);
    run_seq("bl4_eighth", 3'd2, 2'd1, 1'b0, 1'b1, 3'd3, 2'b00);
  endtask

  initial begin
    test_short_burst();
    test_full_page();
    test_coerced_codes();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule